// File: doc/BRIEF.md
# Timer Capture and Compare Channel

This block is one channel hung off the count bus of a free-running timer. It does not own the counter: it watches the count value and the overflow strobe that the timer core drives. In capture mode it watches an external input pin. When it sees the chosen edge, it stores the count of that cycle in a capture register. The timer is not paused or cleared by this. In compare mode and PWM mode it keeps a compare value and drives a dedicated output pin from the relation between the count and that value.

Software writes a new compare value into a pending register. The active compare value copies it only on an overflow strobe, so a period that is running is never cut short. Three sticky flags report activity: match, capture, and capture-while-full (overcapture). Each flag is cleared by writing a one to its bit of the clear strobe. If an event and a clear arrive in the same cycle, the event wins.

Three state machines make up the design:

- **Input level tracker.** States LVL_LOW and LVL_HIGH follow the synchronised pin. The transitions LVL_LOW to LVL_HIGH and LVL_HIGH to LVL_LOW are the rising and falling edges.
- **Capture flag machine.** States CF_EMPTY, CF_HELD, CF_OVERRUN and CF_STALE. Its transitions:
  - capture: CF_EMPTY to CF_HELD, CF_HELD to CF_OVERRUN, CF_STALE to CF_OVERRUN.
  - capture-flag clear: CF_HELD to CF_EMPTY, CF_OVERRUN to CF_STALE.
  - overcapture clear: CF_OVERRUN to CF_HELD, CF_STALE to CF_EMPTY.
  - both clears together: CF_OVERRUN to CF_EMPTY.
- **Output pin machine.** States OUT_LOW and OUT_HIGH. Its transitions:
  - rise: a set or toggle match, or count below compare in PWM mode.
  - fall: a clear or toggle match, or count at or above compare in PWM mode.

Top module: `tmr_cc_channel`

## Requirements
- R1: While reset is asserted, the output pin is low, all three flags are clear and the capture value is zero.
- R2: The pin passes through two synchronising flops. With rising select (edge_fall_i=0) in capture mode, a low-to-high pin change made before clock edge k gives a capture register holding the count presented to edge k+2, visible after edge k+2, together with the capture flag. The count presented to edge k+2 is the count at edge k plus 2.
- R3: With falling select (edge_fall_i=1), only high-to-low changes capture. The edge that is not selected leaves the capture value and the capture flag unchanged.
- R4: A capture taken while the capture flag is set (and not being cleared in that cycle) sets the overcapture flag. The capture value still takes the new count.
- R5: flag_clr_i bit 0 clears the match flag, bit 1 clears the capture flag and bit 2 clears the overcapture flag. An event in the same cycle takes priority over its clear.
- R6: In compare mode, a cycle whose count equals the active compare value applies action_i to the pin, visible after that clock edge. The codes are 00 no change, 01 drive high, 10 drive low and 11 invert.
- R7: The match flag sets on any cycle in compare or PWM mode in which the count equals the active compare value.
- R8: In PWM mode, after each edge the pin shows whether the count presented at that edge was below the active compare value. A compare value of 0 holds the pin low. A compare value above the top count holds it high. Over one full period the pin is high for min(compare, 2^CNT_W) cycles.
- R9: A compare write only loads the pending value. The active value takes it at the edge of a cycle in which ovf_i is high. Until then the old value governs the pin and the match flag.
- R10: mode_i encodes 00 capture, 01 compare, 10 PWM and 11 hold. In hold mode the pin keeps its level and neither captures nor matches occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Count value from the timer core |
| ovf_i | input | 1 | Overflow strobe, high in the cycle the count is at its top value |
| mode_i | input | 2 | Channel mode: 00 capture, 01 compare, 10 PWM, 11 hold |
| edge_fall_i | input | 1 | Capture edge: 0 rising, 1 falling |
| action_i | input | 2 | Compare action: 00 none, 01 set, 10 clear, 11 toggle |
| cmp_wr_i | input | 1 | Write strobe for the pending compare value |
| cmp_wdata_i | input | CNT_W+1 | Compare value to write (one bit wider than the count) |
| flag_clr_i | input | 3 | Write-one-to-clear strobes: bit 0 match, bit 1 capture, bit 2 overcapture |
| cap_pin_i | input | 1 | External capture input, asynchronous |
| out_pin_o | output | 1 | Compare or PWM output pin |
| cap_val_o | output | CNT_W | Latched capture value |
| match_flag_o | output | 1 | Sticky match flag |
| cap_flag_o | output | 1 | Sticky capture flag |
| ovcap_flag_o | output | 1 | Sticky overcapture flag |

## Verification
The properties assume a few things about the inputs:
- mode_i changes only between clock edges.
- ovf_i is a single-cycle strobe that appears once per count period.
- A compare write does not land in the overflow cycle, so the pending and active values stay distinguishable.

The stimulus keeps within these assumptions. A four-bit count advances by one every cycle and ovf_i is high only at the top count. Compare writes are aligned away from the top count before any check that depends on them. Mode, edge select and pin changes are made only at falling clock edges.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'b00,
        MODE_COMPARE = 2'b01,
        MODE_PWM     = 2'b10,
        MODE_HOLD    = 2'b11
    } cc_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_SET    = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_TOGGLE = 2'b11
    } cc_act_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    typedef enum logic [1:0] {
        CF_EMPTY   = 2'b00,
        CF_HELD    = 2'b01,
        CF_OVERRUN = 2'b11,
        CF_STALE   = 2'b10
    } cap_flag_state_e;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } out_state_e;

    localparam int CLR_MATCH = 0;
    localparam int CLR_CAP   = 1;
    localparam int CLR_OVCAP = 2;
    localparam int CLR_W     = 3;

endpackage

// File: rtl/tmr_cc_edge.sv
module tmr_cc_edge
    import tmr_cc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              synced;
    lvl_state_e        state_q;
    lvl_state_e        state_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign synced = sync_q[STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (synced)  state_d = LVL_HIGH;
            LVL_HIGH: if (!synced) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    // outputs: edge reported in the cycle the synced level departs the state
    always_comb begin
        edge_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  edge_o = synced & ~fall_sel_i;
            LVL_HIGH: edge_o = ~synced & fall_sel_i;
            default:  edge_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_cc_capture.sv
module tmr_cc_capture
    import tmr_cc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             evt_i,
    input  logic             clr_cap_i,
    input  logic             clr_ovr_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             cap_flag_o,
    output logic             ovr_flag_o
);

    cap_flag_state_e  state_q;
    cap_flag_state_e  state_d;
    logic [CNT_W-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cap_q <= '0;
        else if (evt_i) cap_q <= cnt_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CF_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: clears apply first, a new capture then wins
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CF_EMPTY: begin
                if (evt_i) state_d = CF_HELD;
            end
            CF_HELD: begin
                if (evt_i && !clr_cap_i)       state_d = CF_OVERRUN;
                else if (!evt_i && clr_cap_i)  state_d = CF_EMPTY;
                else                           state_d = CF_HELD;
            end
            CF_OVERRUN: begin
                if (evt_i && !clr_cap_i)       state_d = CF_OVERRUN;
                else if (evt_i)                state_d = clr_ovr_i ? CF_HELD  : CF_OVERRUN;
                else if (clr_cap_i)            state_d = clr_ovr_i ? CF_EMPTY : CF_STALE;
                else                           state_d = clr_ovr_i ? CF_HELD  : CF_OVERRUN;
            end
            CF_STALE: begin
                if (evt_i) state_d = clr_ovr_i ? CF_HELD  : CF_OVERRUN;
                else       state_d = clr_ovr_i ? CF_EMPTY : CF_STALE;
            end
            default: state_d = CF_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        cap_flag_o = 1'b0;
        ovr_flag_o = 1'b0;
        unique case (state_q)
            CF_EMPTY:   ;
            CF_HELD:    cap_flag_o = 1'b1;
            CF_OVERRUN: begin cap_flag_o = 1'b1; ovr_flag_o = 1'b1; end
            CF_STALE:   ovr_flag_o = 1'b1;
            default:    ;
        endcase
    end

    assign cap_o = cap_q;

endmodule

// File: rtl/tmr_cc_compare.sv
module tmr_cc_compare
    import tmr_cc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    input  cc_mode_e         mode_i,
    input  cc_act_e          act_i,
    input  logic             wr_i,
    input  logic [CNT_W:0]   wdata_i,
    input  logic             clr_match_i,
    output logic             out_o,
    output logic             match_flag_o,
    output logic             match_evt_o,
    output logic [CNT_W:0]   act_cmp_o
);

    localparam int CMP_W = CNT_W + 1;

    logic [CMP_W-1:0] pend_q;
    logic [CMP_W-1:0] act_q;
    logic [CMP_W-1:0] cnt_ext;
    logic             hit;
    logic             below;
    logic             match_q;
    out_state_e       state_q;
    out_state_e       state_d;

    assign cnt_ext = {1'b0, cnt_i};
    assign hit     = (cnt_ext == act_q);
    assign below   = (cnt_ext < act_q);

    // pending value and its transfer at overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (ovf_i) act_q  <= pend_q;
            if (wr_i)  pend_q <= wdata_i;
        end
    end

    assign match_evt_o = hit && (mode_i == MODE_COMPARE || mode_i == MODE_PWM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_evt_o | (match_q & ~clr_match_i);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_LOW;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_LOW: begin
                unique case (mode_i)
                    MODE_COMPARE: if (hit && (act_i == ACT_SET || act_i == ACT_TOGGLE))
                                      state_d = OUT_HIGH;
                    MODE_PWM:     if (below) state_d = OUT_HIGH;
                    default:      state_d = OUT_LOW;
                endcase
            end
            OUT_HIGH: begin
                unique case (mode_i)
                    MODE_COMPARE: if (hit && (act_i == ACT_CLEAR || act_i == ACT_TOGGLE))
                                      state_d = OUT_LOW;
                    MODE_PWM:     if (!below) state_d = OUT_LOW;
                    default:      state_d = OUT_HIGH;
                endcase
            end
            default: state_d = OUT_LOW;
        endcase
    end

    // outputs
    always_comb begin
        out_o = 1'b0;
        unique case (state_q)
            OUT_LOW:  out_o = 1'b0;
            OUT_HIGH: out_o = 1'b1;
            default:  out_o = 1'b0;
        endcase
    end

    assign match_flag_o = match_q;
    assign act_cmp_o    = act_q;

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
    import tmr_cc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    input  logic [1:0]       mode_i,
    input  logic             edge_fall_i,
    input  logic [1:0]       action_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W:0]   cmp_wdata_i,
    input  logic [2:0]       flag_clr_i,
    input  logic             cap_pin_i,
    output logic             out_pin_o,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             match_flag_o,
    output logic             cap_flag_o,
    output logic             ovcap_flag_o
);

    cc_mode_e       mode_w;
    cc_act_e        act_w;
    logic           edge_w;
    logic           cap_evt_w;
    logic           match_evt_w;
    logic [CNT_W:0] act_cmp_w;

    assign mode_w    = cc_mode_e'(mode_i);
    assign act_w     = cc_act_e'(action_i);
    assign cap_evt_w = edge_w && (mode_w == MODE_CAPTURE);

    tmr_cc_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (cap_pin_i),
        .fall_sel_i (edge_fall_i),
        .edge_o     (edge_w)
    );

    tmr_cc_capture #(
        .CNT_W (CNT_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt_i),
        .evt_i      (cap_evt_w),
        .clr_cap_i  (flag_clr_i[CLR_CAP]),
        .clr_ovr_i  (flag_clr_i[CLR_OVCAP]),
        .cap_o      (cap_val_o),
        .cap_flag_o (cap_flag_o),
        .ovr_flag_o (ovcap_flag_o)
    );

    tmr_cc_compare #(
        .CNT_W (CNT_W)
    ) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_i        (cnt_i),
        .ovf_i        (ovf_i),
        .mode_i       (mode_w),
        .act_i        (act_w),
        .wr_i         (cmp_wr_i),
        .wdata_i      (cmp_wdata_i),
        .clr_match_i  (flag_clr_i[CLR_MATCH]),
        .out_o        (out_pin_o),
        .match_flag_o (match_flag_o),
        .match_evt_o  (match_evt_w),
        .act_cmp_o    (act_cmp_w)
    );

endmodule

// File: rtl/tmr_cc_checker.sv
module tmr_cc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             ovf_i,
    input logic [2:0]       flag_clr_i,
    input logic             out_pin_o,
    input logic [CNT_W-1:0] cap_val_o,
    input logic             match_flag_o,
    input logic             cap_flag_o,
    input logic             ovcap_flag_o,
    input logic [CNT_W:0]   act_cmp,
    input logic             cap_evt,
    input logic             match_evt
);

    // R2
    cap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag_o) |-> $past(mode_i == 2'b00));

    // R2
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_val_o));

    // R4
    ovcap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovcap_flag_o) |-> $past(cap_flag_o));

    // R5
    clr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i[1] && !cap_evt) |=> !cap_flag_o);

    // R5
    clr_ovcap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i[2] && !(cap_evt && cap_flag_o)) |=> !ovcap_flag_o);

    // R5
    clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i[0] && !match_evt) |=> !match_flag_o);

    // R7
    match_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag_o) |-> $past(mode_i == 2'b01 || mode_i == 2'b10));

    // R8
    pwm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && act_cmp == '0) |=> !out_pin_o);

    // R9
    shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_i |=> $stable(act_cmp));

    // R10
    hold_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |=> $stable(out_pin_o));

endmodule

bind tmr_cc_channel tmr_cc_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .ovf_i        (ovf_i),
    .flag_clr_i   (flag_clr_i),
    .out_pin_o    (out_pin_o),
    .cap_val_o    (cap_val_o),
    .match_flag_o (match_flag_o),
    .cap_flag_o   (cap_flag_o),
    .ovcap_flag_o (ovcap_flag_o),
    .act_cmp      (act_cmp_w),
    .cap_evt      (cap_evt_w),
    .match_evt    (match_evt_w)
);

// File: tb/sim_tmr_cc_channel.sv
module sim_tmr_cc_channel;

    localparam int W = 4;
    localparam logic [W-1:0] TOP_CNT = '1;
    localparam int PERIOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] cnt;
    logic         ovf;
    logic [1:0]   mode;
    logic         fall;
    logic [1:0]   act;
    logic         cmp_wr;
    logic [W:0]   cmp_wdata;
    logic [2:0]   clr;
    logic         pin;
    logic         run;
    logic         out_pin;
    logic [W-1:0] cap_val;
    logic         match_flag;
    logic         cap_flag;
    logic         ovcap_flag;

    int total = 0;
    int bad   = 0;

    // reference state, computed from the requirements
    logic         m_out, m_mf, m_cf, m_of, m_s1, m_s2, m_prev;
    logic [W:0]   m_act, m_pend;
    logic [W-1:0] m_cap;

    always #2 clk = ~clk;

    assign ovf = run && (cnt == TOP_CNT);

    tmr_cc_channel #(.CNT_W(W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_i        (cnt),
        .ovf_i        (ovf),
        .mode_i       (mode),
        .edge_fall_i  (fall),
        .action_i     (act),
        .cmp_wr_i     (cmp_wr),
        .cmp_wdata_i  (cmp_wdata),
        .flag_clr_i   (clr),
        .cap_pin_i    (pin),
        .out_pin_o    (out_pin),
        .cap_val_o    (cap_val),
        .match_flag_o (match_flag),
        .cap_flag_o   (cap_flag),
        .ovcap_flag_o (ovcap_flag)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int a, input int e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, a, e);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // one clock cycle: predict, clock, compare, advance count
    task automatic cycle(input string tag);
        logic hit, edge_seen, evt, n_out;
        hit = (mode == 2'b01 || mode == 2'b10) && ({1'b0, cnt} == m_act);
        edge_seen = fall ? (!m_s2 && m_prev) : (m_s2 && !m_prev);
        evt = (mode == 2'b00) && edge_seen;
        n_out = m_out;
        if (mode == 2'b01 && hit) begin
            case (act)
                2'b01:   n_out = 1'b1;
                2'b10:   n_out = 1'b0;
                2'b11:   n_out = !m_out;
                default: n_out = m_out;
            endcase
        end else if (mode == 2'b10) begin
            n_out = ({1'b0, cnt} < m_act);
        end
        @(posedge clk);
        m_of = (evt && m_cf && !clr[1]) || (m_of && !clr[2]);
        m_cf = evt || (m_cf && !clr[1]);
        m_mf = hit || (m_mf && !clr[0]);
        if (evt) m_cap = cnt;
        m_out = n_out;
        if (ovf) m_act = m_pend;
        if (cmp_wr) m_pend = cmp_wdata;
        m_prev = m_s2;
        m_s2 = m_s1;
        m_s1 = pin;
        @(negedge clk);
        chk(out_pin === m_out, tag, "out_pin", int'(out_pin), int'(m_out));
        chk(cap_val === m_cap, tag, "cap_val", int'(cap_val), int'(m_cap));
        chk(match_flag === m_mf, tag, "match_flag", int'(match_flag), int'(m_mf));
        chk(cap_flag === m_cf, tag, "cap_flag", int'(cap_flag), int'(m_cf));
        chk(ovcap_flag === m_of, tag, "ovcap_flag", int'(ovcap_flag), int'(m_of));
        if (run) cnt = cnt + 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int ones;
        int exp_ones;
        logic [W-1:0] c0;
        logic [W-1:0] c_seen;
        logic         prev_out;
        logic [W-1:0] prev_cap;
        rst_n = 1'b0; run = 1'b0; cnt = '0; mode = 2'b00; fall = 1'b0; act = 2'b00;
        cmp_wr = 1'b0; cmp_wdata = '0; clr = '0; pin = 1'b0;
        m_out = 0; m_mf = 0; m_cf = 0; m_of = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        m_act = '0; m_pend = '0; m_cap = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_pin === 1'b0, "R1", "out_pin", int'(out_pin), 0);
        chk({match_flag, cap_flag, ovcap_flag} === 3'b000, "R1", "flags",
            int'({match_flag, cap_flag, ovcap_flag}), 0);
        chk(cap_val === '0, "R1", "cap_val", int'(cap_val), 0);
        rst_n = 1'b1;
        run = 1'b1;

        // R8 R9 R7 R5: PWM sweep over every compare value 0..PERIOD+1
        mode = 2'b10;
        for (int a = 0; a <= PERIOD + 1; a++) begin
            cmp_wr = 1'b1; cmp_wdata = (W+1)'(a);
            cycle("R9 pwm write");
            cmp_wr = 1'b0;
            while (m_act != (W+1)'(a)) cycle("R9 pwm pending");
            cycle("R8 pwm settle");
            ones = 0;
            for (int i = 0; i < PERIOD; i++) begin
                cycle("R8 pwm period");
                ones += int'(out_pin);
            end
            exp_ones = (a < PERIOD) ? a : PERIOD;
            chk(ones == exp_ones, "R8", "high cycles per period", ones, exp_ones);
            if (a < PERIOD) chk(match_flag === 1'b1, "R7", "match flag pwm", int'(match_flag), 1);
            clr = 3'b001;
            cycle("R5 clear match");
            clr = '0;
        end

        // R9: new value 0 written mid-period, old value 17 rules until overflow
        while (cnt != 4'd3) cycle("R9 align");
        cmp_wr = 1'b1; cmp_wdata = '0;
        cycle("R9 write");
        cmp_wr = 1'b0;
        do begin
            c_seen = cnt;
            cycle("R9 old value");
            if (c_seen != '0) chk(out_pin === 1'b1, "R9", "pin before overflow", int'(out_pin), 1);
            else              chk(out_pin === 1'b0, "R9", "pin after overflow", int'(out_pin), 0);
        end while (c_seen != '0);

        // R6 R7 R5: compare mode, every action, several compare values
        mode = 2'b01;
        for (int ac = 0; ac < 4; ac++) begin
            for (int v = 0; v < 3; v++) begin
                act = 2'(ac);
                while (cnt == TOP_CNT) cycle("R6 align");
                cmp_wr = 1'b1; cmp_wdata = (W+1)'(3 + 6 * v);
                cycle("R6 write");
                cmp_wr = 1'b0;
                for (int i = 0; i < 40; i++) begin
                    clr[0] = (i % 7 == 0);
                    cycle("R6 compare sweep");
                end
                clr = '0;
                while ({1'b0, cnt} != m_act) cycle("R6 align match");
                prev_out = out_pin;
                cycle("R6 match edge");
                case (ac)
                    0: chk(out_pin === prev_out, "R6", "none action", int'(out_pin), int'(prev_out));
                    1: chk(out_pin === 1'b1, "R6", "set action", int'(out_pin), 1);
                    2: chk(out_pin === 1'b0, "R6", "clear action", int'(out_pin), 0);
                    default: chk(out_pin === !prev_out, "R6", "toggle action", int'(out_pin), int'(!prev_out));
                endcase
                chk(match_flag === 1'b1, "R7", "match flag compare", int'(match_flag), 1);
            end
        end

        // R10: hold mode ignores pin and matches
        mode = 2'b11;
        prev_out = out_pin;
        prev_cap = cap_val;
        clr = 3'b111;
        cycle("R10 clear");
        clr = '0;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            if (i % 3 == 0) pin = !pin;
            act = 2'(i);
            cycle("R10 hold");
        end
        pin = 1'b0;
        repeat (3) cycle("R10 settle");
        chk(out_pin === prev_out, "R10", "pin held", int'(out_pin), int'(prev_out));
        chk(cap_val === prev_cap, "R10", "no capture", int'(cap_val), int'(prev_cap));
        chk({match_flag, cap_flag} === 2'b00, "R10", "no flags",
            int'({match_flag, cap_flag}), 0);

        // R2: rising capture latency and value
        mode = 2'b00; fall = 1'b0;
        repeat (2) cycle("R2 idle");
        c0 = cnt;
        pin = 1'b1;
        repeat (3) cycle("R2 rising");
        chk(cap_val === W'(c0 + 2), "R2", "rising capture value", int'(cap_val), int'(W'(c0 + 2)));
        chk(cap_flag === 1'b1, "R2", "capture flag", int'(cap_flag), 1);

        // R3: unselected edges ignored, falling select captures
        clr = 3'b110;
        cycle("R5 clear capture");
        clr = '0;
        prev_cap = cap_val;
        pin = 1'b0;
        repeat (4) cycle("R3 falling ignored");
        chk(cap_flag === 1'b0 && cap_val === prev_cap, "R3", "falling ignored under rising select",
            int'(cap_val), int'(prev_cap));
        fall = 1'b1;
        pin = 1'b1;
        repeat (4) cycle("R3 rising ignored");
        chk(cap_flag === 1'b0 && cap_val === prev_cap, "R3", "rising ignored under falling select",
            int'(cap_val), int'(prev_cap));
        c0 = cnt;
        pin = 1'b0;
        repeat (3) cycle("R3 falling");
        chk(cap_val === W'(c0 + 2), "R3", "falling capture value", int'(cap_val), int'(W'(c0 + 2)));

        // R4: second capture with flag still set
        pin = 1'b1;
        repeat (3) cycle("R4 idle");
        c0 = cnt;
        pin = 1'b0;
        repeat (3) cycle("R4 second capture");
        chk(ovcap_flag === 1'b1, "R4", "overcapture flag", int'(ovcap_flag), 1);
        chk(cap_val === W'(c0 + 2), "R4", "new capture value", int'(cap_val), int'(W'(c0 + 2)));

        // R2 R3 R4 R5: sweep of pin rates, both edge selects, interleaved clears
        for (int fs = 0; fs < 2; fs++) begin
            fall = fs[0];
            for (int k = 2; k <= 6; k++) begin
                for (int i = 0; i < 48; i++) begin
                    if (i % k == 0) pin = !pin;
                    clr[1] = (i % 11 == 0);
                    clr[2] = (i % 13 == 0);
                    cycle("R4 capture sweep");
                end
                clr = '0;
            end
        end

        summary();
        $finish;
    end

endmodule